// File: doc/BRIEF.md
# Serial Packed-Word Summer

This block adds up a run-time chosen number of signed 16-bit words that arrive side by side on one wide input bus. It does not build one wide multi-input adder. It adds one word per clock cycle into a single 16-bit accumulator. A counter steers a word-select multiplexer, and a three-state controller (idle, accumulating, finished) sequences the operation.

The user places the words on the packed bus and applies the word count. The user then pulses `start` for one cycle. The bus must stay unchanged until `done` is seen. `busy` stays high for the whole operation. `done` is a one-cycle pulse, and in that cycle the final sum is on `result`. The sum is kept until the next accepted start. The parameter `MAX_WORDS` sets the width of the bus and the largest count the block will honour.

Top module: `serial_word_summer`

## Requirements
- R1: After an operation over N words, `result` equals the sum of words 0 to N-1 taken modulo 2^16 (two's-complement wrap). Word i is taken from bits i*16+15 down to i*16 of `data_in`.
- R2: Let E be the rising edge that accepts `start`. `done` is high in the cycle that follows the N-th rising edge after E, and it is high for exactly one cycle.
- R3: A word count of zero raises `done` in the cycle right after the accepting edge, and `result` is zero in that cycle.
- R4: A word count above `MAX_WORDS` is treated as `MAX_WORDS`. Both the sum and the timing of `done` follow the clamped value.
- R5: `busy` goes high in the cycle after the accepting edge. It stays high up to and including the `done` cycle, and it is low in the cycle after `done`.
- R6: A `start` pulse while `busy` is high is ignored. It does not change the final sum, it does not move the `done` cycle, and it does not start a new operation.
- R7: An accepted `start` clears `result` to zero before any word is added. Once the block is idle, `result` keeps its value until the next accepted `start`.
- R8: A synchronous active-high reset leaves `busy` and `done` low and `result` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a summation |
| word_count | input | $clog2(MAX_WORDS+1) | Number of words to add, sampled with an accepted start |
| data_in | input | MAX_WORDS*16 | Packed operand words, word 0 in the lowest 16 bits |
| result | output | 16 | Running and final wrapped sum |
| done | output | 1 | One-cycle pulse when the sum is complete |
| busy | output | 1 | High from acceptance through the done cycle |

## Verification
The accepting edge is E. With a count of N after clamping, `result` reads zero one cycle after E, and `done` together with the final sum appears in the cycle after edge E+N. In the next cycle `busy` falls and the sum is unchanged. The bench drives inputs and samples outputs on the falling edge. It counts exactly N falling edges after the start cycle before it expects `done`, and it checks at every falling edge in between that `done` is still low. Stray `start` pulses are placed in the first accumulating cycle and in the `done` cycle, and the bench checks that neither moves the due cycle of `done` nor changes the sum.

// File: rtl/serial_sum_pkg.sv
package serial_sum_pkg;

    localparam int WORD_W = 16;

    typedef logic signed [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FIN   = 2'd2
    } sum_state_t;

    // Two's-complement add that keeps only WORD_W bits.
    function automatic word_t wrap_add(input word_t a, input word_t b);
        logic [WORD_W:0] wide;
        wide = {a[WORD_W-1], a} + {b[WORD_W-1], b};
        return word_t'(wide[WORD_W-1:0]);
    endfunction

endpackage

// File: rtl/sum_ctrl.sv
module sum_ctrl
    import serial_sum_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    localparam int CNT_W = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] word_count,
    output logic [CNT_W-1:0] sel,
    output logic             clear,
    output logic             add_en,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WORDS);

    sum_state_t       state;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] clamped;
    logic [CNT_W-1:0] sel_next;

    always_comb begin
        clamped  = (word_count > LIMIT) ? LIMIT : word_count;
        sel_next = sel + 1'b1;
        clear    = start && (state == ST_IDLE);
        add_en   = (state == ST_ACCUM);
        busy     = (state != ST_IDLE);
        done     = (state == ST_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sel    <= '0;
            target <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        target <= clamped;
                        sel    <= '0;
                        state  <= (clamped == '0) ? ST_FIN : ST_ACCUM;
                    end
                end
                ST_ACCUM: begin
                    sel <= sel_next;
                    if (sel_next == target) begin
                        state <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/word_mux.sv
module word_mux
    import serial_sum_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    localparam int CNT_W = $clog2(MAX_WORDS + 1),
    localparam int BUS_W = MAX_WORDS * WORD_W
) (
    input  logic [BUS_W-1:0] data_in,
    input  logic [CNT_W-1:0] sel,
    output word_t            word
);

    word_t lane [MAX_WORDS];

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_lane
        assign lane[g] = word_t'(data_in[g*WORD_W +: WORD_W]);
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < MAX_WORDS; i++) begin
            if (sel == CNT_W'(i)) begin
                word = lane[i];
            end
        end
    end

endmodule

// File: rtl/sum_accum.sv
module sum_accum
    import serial_sum_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  add_en,
    input  word_t word,
    output word_t acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= wrap_add(acc, word);
        end
    end

endmodule

// File: rtl/serial_word_summer.sv
module serial_word_summer
    import serial_sum_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    localparam int CNT_W = $clog2(MAX_WORDS + 1),
    localparam int BUS_W = MAX_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [BUS_W-1:0]  data_in,
    output logic [WORD_W-1:0] result,
    output logic              done,
    output logic              busy
);

    logic [CNT_W-1:0] sel;
    logic             clear;
    logic             add_en;
    word_t            cur_word;
    word_t            acc;

    sum_ctrl #(.MAX_WORDS(MAX_WORDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .word_count (word_count),
        .sel        (sel),
        .clear      (clear),
        .add_en     (add_en),
        .busy       (busy),
        .done       (done)
    );

    word_mux #(.MAX_WORDS(MAX_WORDS)) u_mux (
        .data_in (data_in),
        .sel     (sel),
        .word    (cur_word)
    );

    sum_accum u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .add_en (add_en),
        .word   (cur_word),
        .acc    (acc)
    );

    assign result = acc;

endmodule

// File: rtl/serial_sum_checker.sv
module serial_sum_checker
    import serial_sum_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    localparam int CNT_W = $clog2(MAX_WORDS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CNT_W-1:0]  word_count,
    input logic [WORD_W-1:0] result,
    input logic              done,
    input logic              busy
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R2

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && word_count == '0) |=> (done && result == '0));  // R3

    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);  // R5

    AST_BUSY_FALLS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);  // R5

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);  // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && result == '0));  // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));  // R7

endmodule

bind serial_word_summer serial_sum_checker #(.MAX_WORDS(MAX_WORDS)) u_chk (.*);

// File: tb/tb_serial_word_summer.sv
module tb_serial_word_summer;

    localparam int MW    = 4;
    localparam int CW    = 3;
    localparam int BW    = MW * 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] word_count = '0;
    logic [BW-1:0] data_in = '0;
    logic [15:0]   result;
    logic          done;
    logic          busy;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    serial_word_summer #(.MAX_WORDS(MW)) dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .word_count (word_count),
        .data_in    (data_in),
        .result     (result),
        .done       (done),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] ref_sum(input logic [BW-1:0] d, input int nc);
        logic [15:0] s = '0;
        for (int k = 0; k < nc; k++) s = s + d[k*16 +: 16];
        return s;
    endfunction

    // One operation; poke adds stray starts while busy (R6).
    task automatic run(input logic [BW-1:0] d, input int n, input bit poke);
        int          nc;
        logic [15:0] exp;
        string       tag;
        nc  = (n > MW) ? MW : n;
        exp = ref_sum(d, nc);
        tag = (n > MW) ? "R4" : ((n == 0) ? "R3" : "R1");
        data_in    = d;
        word_count = CW'(n);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (nc > 0) chk(result == 16'h0, "R7 clear", int'(result), 0);
        for (int k = 0; k < nc; k++) begin
            chk(!done && busy, "R2/R5 early", {done, busy}, 1);
            if (poke && k == 0) begin
                start      = 1'b1;
                word_count = CW'(1);
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(done == 1'b1, (n == 0) ? "R3 done" : "R2 done", int'(done), 1);
        chk(busy == 1'b1, "R5 busy at done", int'(busy), 1);
        chk(result == exp, tag, int'(result), int'(exp));
        if (poke) begin
            start      = 1'b1;
            word_count = CW'(2);
        end
        @(negedge clk);
        start = 1'b0;
        chk(!done && !busy, poke ? "R6 ignored" : "R5 end", {done, busy}, 0);
        @(negedge clk);
        chk(result == exp, "R7 hold", int'(result), int'(exp));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [BW-1:0] pat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && result == 16'h0, "R8 reset", {busy, done}, 0);
        for (int p = 0; p < 7; p++) begin
            case (p)
                0: pat = {16'h0004, 16'h0003, 16'h0002, 16'h0001};
                1: pat = {4{16'h7FFF}};
                2: pat = {4{16'h8000}};
                3: pat = {16'hFFFF, 16'h0001, 16'hFFFF, 16'h0001};
                4: pat = {16'h8001, 16'h7FFF, 16'hC000, 16'h4000};
                default: pat = {$urandom, $urandom};
            endcase
            for (int n = 0; n < 8; n++) run(pat, n, 1'b0);
        end
        run({16'h1111, 16'h2222, 16'h3333, 16'h4444}, 3, 1'b1);  // R6
        run({16'hA5A5, 16'h5A5A, 16'h0F0F, 16'hF0F0}, 4, 1'b1);  // R6
        run({16'h0100, 16'h0200, 16'h0300, 16'h0400}, 0, 1'b1);  // R6 with R3
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && result == 16'h0, "R8 re-reset", int'(result), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule